// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is a synthesizable model of a 2 KiB serial EEPROM that sits on a two-wire bus. The bus is clocked by an external master. The array holds eight 256-byte blocks, and each block is split into 16-byte write pages. The model samples the bus clock and data lines with the system clock. It drives the data line only through an open-drain pull-down output: a 1 on `sda_pull_o` means "hold the line low". An active-high protect input blocks changes to the array.

A transaction begins with a START condition, followed by a control byte. The control byte carries a device-type code in its upper nibble, three block-select bits in bits 3..1, and a direction bit in bit 0. A write sends a word address and then page data. The data is held in a page buffer and is committed only when a STOP arrives. Programming then runs on its own for a fixed number of system clocks. Reads return bytes from an internal pointer, and they carry on for as long as the master acknowledges each byte.

The bus has no valid/ready stream. All flow control follows the bus protocol itself: the slave acknowledges each byte it receives, and the master acknowledges each byte it reads.

Top module: `eep_twowire`

## Requirements
- R1: A control byte is acknowledged only when its bits 7..4 equal 4'b1010. With any other code the slave never pulls SDA low and waits for the next START.
- R2: For every byte the slave accepts, it holds SDA low during the whole high phase of the ninth SCL clock. It changes its pull-down only while SCL is low.
- R3: On a write, the word address selects the page with bits 7..4 and the byte within the page with bits 3..0. Data beyond 16 bytes wraps to the start of the same page, so the 17th byte lands where the 1st did.
- R4: Nothing is programmed before STOP. At STOP, only the bytes loaded into the page buffer are written, and the other bytes of that page keep their values.
- R5: If STOP arrives after at least one bit of a data byte has been clocked in, the whole write is dropped and the slave is not busy afterwards.
- R6: After a committed write, the slave is busy for PROG_CYCLES system clocks. During that time START, STOP and control bytes are ignored, and no byte is acknowledged.
- R7: While `wp_i` is high at STOP, write bytes are still acknowledged, but the array is not changed and no busy period starts.
- R8: A random read (a write control byte, then the address, then a repeated START and a read control byte) returns the byte at {block bits, address}. Data is sent MSB first, changing while SCL is low.
- R9: Each byte the master acknowledges is followed by the byte at the next address. The address crosses block boundaries and wraps from 0x7FF to 0x000.
- R10: When the master does not acknowledge a read byte, the slave releases SDA and ignores further clocks until a START.
- R11: A repeated START in the middle of a write ends that write without programming it, and decoding starts afresh.
- R12: A read control byte with no address first (a current read) returns the byte at the internal pointer. The pointer is one past the last byte sent, and the block bits of that control byte are not used.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock level |
| sda_i | input | 1 | Bus data level (wired line) |
| wp_i | input | 1 | Write protect, active high |
| sda_pull_o | output | 1 | 1 pulls the data line low (open drain) |

## Verification
On every cycle, the embedded properties check the following. The pull-down changes only after a low SCL sample. The output stays released while the slave is idle or programming. The busy period cannot end early. The array is never written with an empty byte mask. Which bytes actually land in the array, how a page wraps, the mid-byte abort, write protection, the pointer carrying across block and array ends, and the busy-time polling can only be shown by the bench's bus scenarios. The bench compares every byte read back against its own reference copy of the array.

// File: rtl/eep_pkg.sv
package eep_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_RACK, ST_PROG
  } eep_state_t;

  typedef enum logic [1:0] {
    RL_CTRL, RL_ADDR, RL_DATA
  } eep_role_t;

  localparam logic [3:0] DEV_CODE = 4'b1010;
endpackage

// File: rtl/eep_bus_cond.sv
module eep_bus_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, scl_qq, sda_q, sda_qq;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q  <= 1'b1;
      scl_qq <= 1'b1;
      sda_q  <= 1'b1;
      sda_qq <= 1'b1;
    end else begin
      scl_q  <= scl_i;
      scl_qq <= scl_q;
      sda_q  <= sda_i;
      sda_qq <= sda_q;
    end
  end

  assign scl_lvl   = scl_q;
  assign sda_lvl   = sda_q;
  assign scl_rise  = scl_q & ~scl_qq;
  assign scl_fall  = ~scl_q & scl_qq;
  assign start_det = scl_q & scl_qq & sda_qq & ~sda_q;
  assign stop_det  = scl_q & scl_qq & ~sda_qq & sda_q;
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int PAGE_BYTES = 16,
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clr,
  input  logic                        we,
  input  logic [PW-1:0]               idx,
  input  logic [7:0]                  din,
  output logic [PAGE_BYTES-1:0][7:0]  data,
  output logic [PAGE_BYTES-1:0]       mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   mask <= '0;
    else if (clr) mask <= '0;
    else if (we)  mask[idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (we) data[idx] <= din;
  end

  // R3
  ld_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !clr) |=> mask[$past(idx)]);
endmodule

// File: rtl/eep_array.sv
module eep_array #(
  parameter int MEM_BYTES  = 2048,
  parameter int PAGE_BYTES = 16,
  localparam int AW = $clog2(MEM_BYTES),
  localparam int PW = $clog2(PAGE_BYTES)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [AW-1:0]               rd_addr,
  output logic [7:0]                  rd_data,
  input  logic                        wr_en,
  input  logic [AW-PW-1:0]            wr_page,
  input  logic [PAGE_BYTES-1:0][7:0]  wr_data,
  input  logic [PAGE_BYTES-1:0]       wr_mask
);
  logic [7:0] mem [MEM_BYTES];

  always_ff @(posedge clk) begin
    for (int i = 0; i < PAGE_BYTES; i++) begin
      if (wr_en && wr_mask[i]) mem[{wr_page, PW'(i)}] <= wr_data[i];
    end
  end

  assign rd_data = mem[rd_addr];

  // R4
  wr_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (|wr_mask));
endmodule

// File: rtl/eep_twowire.sv
module eep_twowire
  import eep_pkg::*;
#(
  parameter int MEM_BYTES   = 2048,
  parameter int PAGE_BYTES  = 16,
  parameter int PROG_CYCLES = 2000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_pull_o
);
  localparam int AW = $clog2(MEM_BYTES);
  localparam int PW = $clog2(PAGE_BYTES);
  localparam int BW = AW - 8;
  localparam int CW = $clog2(PROG_CYCLES);

  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  eep_state_t st;
  eep_role_t  role;
  logic [3:0]    bitcnt;
  logic [7:0]    shreg, txsh, rd_data;
  logic [AW-1:0] ptr;
  logic [BW-1:0] blk_q;
  logic          rw_q, pull_q;
  logic [CW-1:0] prog_cnt;
  logic [PAGE_BYTES-1:0][7:0] pb_data;
  logic [PAGE_BYTES-1:0]      pb_mask;
  logic byte_done, dev_ok, pb_clr, pb_we, prog_go;

  eep_bus_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_det(start_det), .stop_det(stop_det)
  );

  assign byte_done = (st == ST_RX) && scl_fall && (bitcnt == 4'd8);
  assign dev_ok    = (shreg[7:4] == DEV_CODE);
  assign pb_clr    = byte_done && (role == RL_ADDR);
  assign pb_we     = byte_done && (role == RL_DATA);
  assign prog_go   = stop_det && (st == ST_RX) && (role == RL_DATA) &&
                     (bitcnt < 4'd2) && (|pb_mask) && !wp_i;

  eep_page_buf #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk(clk), .rst_n(rst_n), .clr(pb_clr), .we(pb_we),
    .idx(ptr[PW-1:0]), .din(shreg), .data(pb_data), .mask(pb_mask)
  );

  eep_array #(.MEM_BYTES(MEM_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_array (
    .clk(clk), .rst_n(rst_n), .rd_addr(ptr), .rd_data(rd_data),
    .wr_en(prog_go), .wr_page(ptr[AW-1:PW]), .wr_data(pb_data),
    .wr_mask(pb_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      role     <= RL_CTRL;
      bitcnt   <= '0;
      shreg    <= '0;
      txsh     <= '0;
      ptr      <= '0;
      blk_q    <= '0;
      rw_q     <= 1'b0;
      pull_q   <= 1'b0;
      prog_cnt <= '0;
    end else if (st == ST_PROG) begin
      if (prog_cnt == '0) st <= ST_IDLE;
      else                prog_cnt <= prog_cnt - 1'b1;
    end else if (start_det) begin
      st     <= ST_RX;
      role   <= RL_CTRL;
      bitcnt <= '0;
      pull_q <= 1'b0;
      rw_q   <= 1'b0;
    end else if (stop_det) begin
      pull_q <= 1'b0;
      if (prog_go) begin
        st       <= ST_PROG;
        prog_cnt <= CW'(PROG_CYCLES - 1);
      end else begin
        st <= ST_IDLE;
      end
    end else begin
      case (st)
        ST_RX: begin
          if (scl_rise && bitcnt != 4'd8) begin
            shreg  <= {shreg[6:0], sda_lvl};
            bitcnt <= bitcnt + 1'b1;
          end
          if (byte_done) begin
            bitcnt <= '0;
            case (role)
              RL_CTRL: begin
                if (dev_ok) begin
                  st     <= ST_ACK;
                  pull_q <= 1'b1;
                  rw_q   <= shreg[0];
                  if (!shreg[0]) begin
                    blk_q <= shreg[BW:1];
                    role  <= RL_ADDR;
                  end
                end else begin
                  st <= ST_IDLE;
                end
              end
              RL_ADDR: begin
                ptr    <= {blk_q, shreg};
                role   <= RL_DATA;
                st     <= ST_ACK;
                pull_q <= 1'b1;
              end
              default: begin
                ptr    <= {ptr[AW-1:PW], PW'(ptr[PW-1:0] + 1'b1)};
                st     <= ST_ACK;
                pull_q <= 1'b1;
              end
            endcase
          end
        end
        ST_ACK: if (scl_fall) begin
          if (rw_q) begin
            st     <= ST_TX;
            pull_q <= ~rd_data[7];
            txsh   <= {rd_data[6:0], 1'b0};
            bitcnt <= 4'd1;
          end else begin
            st     <= ST_RX;
            pull_q <= 1'b0;
          end
        end
        ST_TX: if (scl_fall) begin
          if (bitcnt == 4'd8) begin
            pull_q <= 1'b0;
            st     <= ST_RACK;
            ptr    <= ptr + 1'b1;
            bitcnt <= '0;
          end else begin
            pull_q <= ~txsh[7];
            txsh   <= {txsh[6:0], 1'b0};
            bitcnt <= bitcnt + 1'b1;
          end
        end
        ST_RACK: if (scl_rise) st <= sda_lvl ? ST_IDLE : ST_ACK;
        default: ;
      endcase
    end
  end

  assign sda_pull_o = pull_q;

  // R2
  sda_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(pull_q) |-> !$past(scl_lvl));
  // R6
  prog_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG && prog_cnt != '0) |=> (st == ST_PROG));
  // R6
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_PROG) |-> !sda_pull_o);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull_o);
endmodule

// File: tb/eep_twowire_test.sv
module eep_twowire_test;
  localparam int Q    = 4;
  localparam int PROG = 600;
  localparam int MEMB = 2048;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic wp = 1'b0;
  logic sda_pull;
  logic sda_line;
  bit   done = 1'b0;

  assign sda_line = sda_m & ~sda_pull;
  always #5 clk = ~clk;

  eep_twowire #(.PROG_CYCLES(PROG)) uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .wp_i(wp), .sda_pull_o(sda_pull)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] ref_mem [MEMB];
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];
  string      tag_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin : mon
    logic [7:0] g, e;
    string t;
    if (got_q.size() > 0) begin
      g = got_q.pop_front();
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(g === e, t, int'(g), int'(e));
      end else begin
        chk(1'b0, "scoreboard underflow", int'(g), 0);
      end
    end
  end

  function automatic logic [7:0] dgen(input int seed, input int i);
    return 8'(seed * 31 + i * 13 + 5);
  endfunction

  function automatic logic [7:0] ctl(input int blk, input bit rd);
    return 8'hA0 | 8'((blk & 7) << 1) | {7'd0, rd};
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic i2c_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic i2c_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_bit(input bit b);
    sda_m = b;    tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    ack = (sda_line == 1'b0);
    tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit mack);
    logic [7:0] b;
    b = '0;
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl_m = 1'b1; tick(Q);
      b = {b[6:0], sda_line};
      tick(Q);
      scl_m = 1'b0;
    end
    tick(Q);
    sda_m = mack ? 1'b0 : 1'b1; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
    got_q.push_back(b);
  endtask

  task automatic expect_bytes(input int addr, input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      exp_q.push_back(ref_mem[(addr + i) % MEMB]);
      tag_q.push_back(tag);
    end
  endtask

  task automatic model_write(input int blk, input int a, input int n, input int seed);
    for (int i = 0; i < n; i++)
      ref_mem[blk * 256 + (a & 'hF0) + ((a + i) & 'hF)] = dgen(seed, i);
  endtask

  task automatic load_data(input int blk, input int a, input int n, input int seed, input string tag);
    bit ack;
    i2c_start();
    send_byte(ctl(blk, 1'b0), ack);
    chk(ack, {tag, " ctrl ack R2"}, ack, 1);
    send_byte(8'(a), ack);
    chk(ack, {tag, " addr ack R2"}, ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(dgen(seed, i), ack);
      chk(ack, {tag, " data ack R2"}, ack, 1);
    end
  endtask

  task automatic poll_ready(output int nacks);
    bit ack;
    nacks = 0;
    for (int k = 0; k < 40; k++) begin
      i2c_start();
      send_byte(ctl(0, 1'b0), ack);
      i2c_stop();
      if (ack) break;
      nacks++;
    end
  endtask

  task automatic full_write(input int blk, input int a, input int n, input int seed, input string tag);
    int nacks;
    load_data(blk, a, n, seed, tag);
    i2c_stop();
    model_write(blk, a, n, seed);
    poll_ready(nacks);
    // R6: busy right after commit, then ready
    chk(nacks >= 1 && nacks < 40, "R6 busy polling", nacks, 1);
  endtask

  task automatic random_read(input int blk, input int a, input int n, input string tag);
    bit ack;
    expect_bytes(blk * 256 + a, n, tag);
    i2c_start();
    send_byte(ctl(blk, 1'b0), ack);
    chk(ack, {tag, " ctrl"}, ack, 1);
    send_byte(8'(a), ack);
    chk(ack, {tag, " addr"}, ack, 1);
    i2c_start();
    send_byte(ctl(blk, 1'b1), ack);
    chk(ack, {tag, " read ctrl"}, ack, 1);
    for (int i = 0; i < n; i++) recv_byte(i != n - 1);
    i2c_stop();
    tick(4);
  endtask

  initial begin
    bit ack;
    int nacks;
    bit seen;
    for (int i = 0; i < MEMB; i++) ref_mem[i] = 8'h00;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    chk(sda_pull == 1'b0, "reset release R10", sda_pull, 0);

    // R1: wrong device code ignored, right one acknowledged
    i2c_start();
    send_byte(8'hB0, ack);
    chk(!ack, "R1 bad code nack", ack, 0);
    i2c_stop();
    i2c_start();
    send_byte(8'hA0, ack);
    chk(ack, "R1 good code ack", ack, 1);
    i2c_stop();

    // R4/R8: full page write then random read
    full_write(2, 'h30, 16, 1, "R4 page");
    random_read(2, 'h30, 16, "R8 random read");

    // R4: partial page, others unchanged
    full_write(2, 'h32, 2, 9, "R4 partial");
    random_read(2, 'h30, 16, "R4 partial readback");

    // R3: 17 bytes wrap inside page
    full_write(2, 'h3E, 17, 4, "R3 wrap");
    random_read(2, 'h30, 16, "R3 wrap readback");

    // R5: STOP mid-byte aborts whole write
    full_write(4, 'h10, 16, 7, "R5 setup");
    load_data(4, 'h10, 1, 12, "R5 load");
    for (int i = 0; i < 4; i++) send_bit(1'b1);
    i2c_stop();
    i2c_start();
    send_byte(ctl(0, 1'b0), ack);
    chk(ack, "R5 not busy after abort", ack, 1);
    i2c_stop();
    random_read(4, 'h10, 16, "R5 unchanged");

    // R7: write protect
    wp = 1'b1;
    load_data(4, 'h10, 3, 21, "R7 protected");
    i2c_stop();
    i2c_start();
    send_byte(ctl(0, 1'b0), ack);
    chk(ack, "R7 no busy period", ack, 1);
    i2c_stop();
    wp = 1'b0;
    random_read(4, 'h10, 16, "R7 unchanged");

    // R11: repeated START aborts a pending write
    load_data(4, 'h14, 2, 33, "R11 load");
    random_read(4, 'h10, 8, "R11 restart read");
    i2c_start();
    send_byte(ctl(0, 1'b0), ack);
    chk(ack, "R11 not busy", ack, 1);
    i2c_stop();

    // R9: sequential across block and array end
    full_write(2, 'hF0, 16, 40, "R9 setup a");
    full_write(3, 'h00, 16, 41, "R9 setup b");
    random_read(2, 'hFE, 4, "R9 block cross");
    full_write(7, 'hF0, 16, 42, "R9 setup c");
    full_write(0, 'h00, 16, 43, "R9 setup d");
    random_read(7, 'hFF, 2, "R9 array wrap");

    // R12: current read from pointer (0x001), block bits ignored
    expect_bytes(1, 1, "R12 current read");
    i2c_start();
    send_byte(ctl(5, 1'b1), ack);
    chk(ack, "R12 ctrl ack", ack, 1);
    recv_byte(1'b0);

    // R10: after nack the slave stays released for further clocks
    seen = 1'b0;
    for (int i = 0; i < 9; i++) begin
      sda_m = 1'b0; tick(Q);
      scl_m = 1'b1; tick(Q);
      if (sda_pull) seen = 1'b1;
      tick(Q);
      scl_m = 1'b0; tick(Q);
    end
    chk(!seen, "R10 released after nack", seen, 0);
    i2c_stop();

    // R6: ready again and data from programming intact
    poll_ready(nacks);
    chk(nacks == 0, "R6 idle not busy", nacks, 0);

    tick(20);
    chk(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule